// File: doc/BRIEF.md
# Floppy Drive Configuration Register

This block holds the 8-bit configuration byte that the local disk-controller processor writes to choose the drive, the side, the clock rate and the recording density for a floppy disk controller chip. The two low bits name one of four drives. The drive-size bit sends that drive number to one of two separate select groups: one for the large-drive connector and one for the small-drive connector. The other bits drive the side line, the controller clock-rate line, the density line, an interrupt-enable gate, a write-protect flag and a busy flag that the host bus can read.

The controller chip's head-load request is ANDed with the decoded selects, so only the selected drive receives it. A rising head-load edge starts a one-shot timer, and the head-settled input returned to the controller stays low until that timer has run out. The controller's command-complete interrupt reaches the local processor's non-maskable interrupt only while the enable bit is set. Three two-colour indicators show the size, density and side. Each indicator output is 1 for green.

Top module: `floppy_cfg_reg`

## Requirements
- R1: A write (`wr_en` high at a clock edge) stores `wr_data`, and `rd_data` shows the stored byte after that edge. Synchronous reset clears the byte and every registered output to 0.
- R2: Bits 1:0 are a drive number that is decoded to a one-hot select. Bit 3 = 1 drives the select on `big_sel`, and `small_sel` is then 0. Bit 3 = 0 drives it on `small_sel`, and `big_sel` is then 0. At most one select line is ever high.
- R3: `side_b` equals bit 2 (1 = side B).
- R4: `clk_8in` equals bit 3 (1 = clock rate for 8-inch drives).
- R5: `single_den` equals bit 4 (1 = single density).
- R6: `nmi_out` is high one edge after `intrq_in` is sampled high while bit 5 is 1. While bit 5 is 0, `intrq_in` has no effect on `nmi_out`.
- R7: `wprot_flag` equals bit 6 and `host_busy` equals bit 7.
- R8: `big_head` and `small_head` equal the selects of the same group ANDed with `head_load_in`. They are registered, so they change one edge after `head_load_in` changes, and a head line is never high while its select is low.
- R9: `head_settled` rises SETTLE_CYC+1 edges after the first edge that samples `head_load_in` high. It falls one edge after `head_load_in` is sampled low. A new rising head-load edge restarts the full delay.
- R10: The indicators show green (1) when the bit is in this state: `led_size_green` for the 8-inch setting, `led_den_green` for single density, and `led_side_green` for side A. Configuration byte 8'h18 therefore lights all three green.
- R11: The decoded selects, `side_b`, `clk_8in`, `single_den`, `wprot_flag`, `host_busy` and the indicators change on the second edge after the write, one edge after `rd_data` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration byte |
| wr_data | input | 8 | Configuration byte to store |
| head_load_in | input | 1 | Head-load request from the controller chip |
| intrq_in | input | 1 | Command-complete interrupt from the controller chip |
| rd_data | output | 8 | Stored configuration byte |
| big_sel | output | 4 | One-hot drive selects, large-drive connector |
| small_sel | output | 4 | One-hot drive selects, small-drive connector |
| big_head | output | 4 | Per-drive head load, large-drive connector |
| small_head | output | 4 | Per-drive head load, small-drive connector |
| side_b | output | 1 | Side select, 1 = side B |
| clk_8in | output | 1 | Controller clock-rate select, 1 = 8-inch |
| single_den | output | 1 | Density select, 1 = single density |
| wprot_flag | output | 1 | Write-protect flag |
| host_busy | output | 1 | Busy flag shown to the host |
| nmi_out | output | 1 | Non-maskable interrupt to the local processor |
| head_settled | output | 1 | Delayed head-loaded timing input to the controller |
| led_size_green | output | 1 | Size indicator, 1 = green (8-inch) |
| led_den_green | output | 1 | Density indicator, 1 = green (single density) |
| led_side_green | output | 1 | Side indicator, 1 = green (side A) |

## Verification
Some properties hold on every cycle, and the assertions check those: at most one select line is high, only the group that agrees with the clock-rate line is active, no head line is high without its select, the interrupt passes only when it was enabled on the previous cycle, and the head-settled line is high only after head load was held. Other behaviour depends on the value written and on exact timing, and only the bench's scenarios show it. That covers the drive number that lands on each select bit, the two-edge latency from a write, the exact SETTLE_CYC+1 delay of the one-shot and its restart after a short drop, and the indicator colours for the all-green setting.

// File: rtl/fdcfg_pkg.sv
package fdcfg_pkg;

  localparam int CFG_W   = 8;
  localparam int NUM_DRV = 4;
  localparam int DRV_W   = $clog2(NUM_DRV);

  // Field layout of the configuration byte, MSB first.
  typedef struct packed {
    logic             busy;       // bit 7
    logic             wprot;      // bit 6
    logic             nmi_en;     // bit 5
    logic             single_den; // bit 4
    logic             clk_8in;    // bit 3
    logic             side_b;     // bit 2
    logic [DRV_W-1:0] drive;      // bits 1:0
  } cfg_t;

endpackage

// File: rtl/fdcfg_store.sv
module fdcfg_store
  import fdcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output cfg_t             cfg
);

  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (wr_en) cfg <= cfg_t'(wr_data);
  end

endmodule

// File: rtl/fdcfg_drive_dec.sv
module fdcfg_drive_dec #(
  parameter int NUM_DRV = 4,
  localparam int DRV_W  = $clog2(NUM_DRV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DRV_W-1:0]   drive,
  input  logic               use_big,
  input  logic               head_load,
  output logic [NUM_DRV-1:0] big_sel,
  output logic [NUM_DRV-1:0] small_sel,
  output logic [NUM_DRV-1:0] big_head,
  output logic [NUM_DRV-1:0] small_head
);

  // Each drive line has its own flops. Selects and head lines come from
  // the same source, so a head line can never lead its select.
  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    logic hit;
    assign hit = (drive == DRV_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        big_sel[g]    <= 1'b0;
        small_sel[g]  <= 1'b0;
        big_head[g]   <= 1'b0;
        small_head[g] <= 1'b0;
      end else begin
        big_sel[g]    <= hit &  use_big;
        small_sel[g]  <= hit & ~use_big;
        big_head[g]   <= hit &  use_big & head_load;
        small_head[g] <= hit & ~use_big & head_load;
      end
    end
  end

endmodule

// File: rtl/fdcfg_settle.sv
module fdcfg_settle #(
  parameter int SETTLE_CYC = 16,
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic head_load,
  output logic settled
);

  logic             hl_prev;
  logic [CNT_W-1:0] remain;
  logic             hl_rise;

  assign hl_rise = head_load & ~hl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hl_prev <= 1'b0;
      remain  <= '0;
      settled <= 1'b0;
    end else begin
      hl_prev <= head_load;
      if (hl_rise)
        remain <= CNT_W'(SETTLE_CYC);
      else if (remain != '0)
        remain <= remain - 1'b1;
      settled <= head_load & hl_prev & (remain == '0);
    end
  end

endmodule

// File: rtl/floppy_cfg_reg.sv
module floppy_cfg_reg
  import fdcfg_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CFG_W-1:0]   wr_data,
  input  logic               head_load_in,
  input  logic               intrq_in,
  output logic [CFG_W-1:0]   rd_data,
  output logic [NUM_DRV-1:0] big_sel,
  output logic [NUM_DRV-1:0] small_sel,
  output logic [NUM_DRV-1:0] big_head,
  output logic [NUM_DRV-1:0] small_head,
  output logic               side_b,
  output logic               clk_8in,
  output logic               single_den,
  output logic               wprot_flag,
  output logic               host_busy,
  output logic               nmi_out,
  output logic               head_settled,
  output logic               led_size_green,
  output logic               led_den_green,
  output logic               led_side_green
);

  cfg_t cfg;

  fdcfg_store u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg)
  );

  assign rd_data = cfg;

  fdcfg_drive_dec #(.NUM_DRV(NUM_DRV)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .drive      (cfg.drive),
    .use_big    (cfg.clk_8in),
    .head_load  (head_load_in),
    .big_sel    (big_sel),
    .small_sel  (small_sel),
    .big_head   (big_head),
    .small_head (small_head)
  );

  fdcfg_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst       (rst),
    .head_load (head_load_in),
    .settled   (head_settled)
  );

  // Controller lines, flags, indicators and interrupt gate, all registered.
  always_ff @(posedge clk) begin
    if (rst) begin
      side_b         <= 1'b0;
      clk_8in        <= 1'b0;
      single_den     <= 1'b0;
      wprot_flag     <= 1'b0;
      host_busy      <= 1'b0;
      nmi_out        <= 1'b0;
      led_size_green <= 1'b0;
      led_den_green  <= 1'b0;
      led_side_green <= 1'b0;
    end else begin
      side_b         <= cfg.side_b;
      clk_8in        <= cfg.clk_8in;
      single_den     <= cfg.single_den;
      wprot_flag     <= cfg.wprot;
      host_busy      <= cfg.busy;
      nmi_out        <= intrq_in & cfg.nmi_en;
      led_size_green <= cfg.clk_8in;
      led_den_green  <= cfg.single_den;
      led_side_green <= ~cfg.side_b;
    end
  end

endmodule

// File: rtl/floppy_cfg_reg_chk.sv
module floppy_cfg_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rd_data,
  input logic [3:0] big_sel,
  input logic [3:0] small_sel,
  input logic [3:0] big_head,
  input logic [3:0] small_head,
  input logic       clk_8in,
  input logic       intrq_in,
  input logic       nmi_out,
  input logic       head_load_in,
  input logic       head_settled
);

  p_one_sel_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({big_sel, small_sel}));

  p_big_group_r2: assert property (@(posedge clk) disable iff (rst)
    (|big_sel) |-> clk_8in);

  p_small_group_r2: assert property (@(posedge clk) disable iff (rst)
    (|small_sel) |-> !clk_8in);

  p_head_gate_r8: assert property (@(posedge clk) disable iff (rst)
    ((big_head & ~big_sel) == 4'b0) && ((small_head & ~small_sel) == 4'b0));

  p_nmi_gate_r6: assert property (@(posedge clk) disable iff (rst)
    nmi_out |-> $past(intrq_in && rd_data[5]));

  p_settle_held_r9: assert property (@(posedge clk) disable iff (rst)
    head_settled |-> $past(head_load_in));

endmodule

bind floppy_cfg_reg floppy_cfg_reg_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_data      (rd_data),
  .big_sel      (big_sel),
  .small_sel    (small_sel),
  .big_head     (big_head),
  .small_head   (small_head),
  .clk_8in      (clk_8in),
  .intrq_in     (intrq_in),
  .nmi_out      (nmi_out),
  .head_load_in (head_load_in),
  .head_settled (head_settled)
);

// File: tb/floppy_cfg_reg_tb.sv
module floppy_cfg_reg_tb;

  localparam int CLK_P  = 10;
  localparam int SETTLE = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       head_load_in = 1'b0;
  logic       intrq_in = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] big_sel, small_sel, big_head, small_head;
  logic       side_b, clk_8in, single_den, wprot_flag, host_busy;
  logic       nmi_out, head_settled;
  logic       led_size_green, led_den_green, led_side_green;

  always #(CLK_P/2) clk = ~clk;

  floppy_cfg_reg #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .head_load_in(head_load_in), .intrq_in(intrq_in), .rd_data(rd_data),
    .big_sel(big_sel), .small_sel(small_sel), .big_head(big_head),
    .small_head(small_head), .side_b(side_b), .clk_8in(clk_8in),
    .single_den(single_den), .wprot_flag(wprot_flag), .host_busy(host_busy),
    .nmi_out(nmi_out), .head_settled(head_settled),
    .led_size_green(led_size_green), .led_den_green(led_den_green),
    .led_side_green(led_side_green)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  mon_ev;

  function automatic logic [23:0] observe();
    return {rd_data, big_sel, small_sel, side_b, clk_8in, single_den,
            wprot_flag, host_busy, led_size_green, led_den_green,
            led_side_green};
  endfunction

  // Expected outputs from the byte alone (field positions from R2-R10).
  function automatic logic [23:0] model(input logic [7:0] b);
    logic [3:0] sel;
    sel = 4'b0001 << b[1:0];
    return {b, (b[3] ? sel : 4'b0), (b[3] ? 4'b0 : sel), b[2], b[3], b[4],
            b[6], b[7], b[3], b[4], ~b[2]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the outputs now.
  initial begin
    forever begin
      @(mon_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, 32'(observe()), 32'(it.exp));
      end
    end
  end

  // Driver: write at one edge, rd_data after it, the rest after the next (R1, R11).
  task automatic write_cfg(input logic [7:0] b, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    check({"R1 readback ", tag}, 32'(rd_data), 32'(b));
    @(negedge clk);
    sb_q.push_back('{exp: model(b), tag: tag});
    ->mon_ev;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 32'(observe()), 32'h0);
    check("R1 reset heads", 32'({big_head, small_head, nmi_out, head_settled}), 32'h0);
    rst = 1'b0;

    // R11: one edge after the write only rd_data has moved.
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h0A;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 sel not yet updated", 32'(big_sel), 32'(4'b0000));
    @(negedge clk);
    check("R11 sel updated", 32'(big_sel), 32'(4'b0100));

    // R2..R7, R10 through the scoreboard.
    write_cfg(8'h00, "R2 small drive0");
    write_cfg(8'h03, "R2 small drive3");
    write_cfg(8'h09, "R2 big drive1");
    write_cfg(8'h0E, "R3 side B big drive2");
    write_cfg(8'h18, "R10 all green");
    write_cfg(8'h10, "R5 single density small");
    write_cfg(8'h40, "R7 write protect");
    write_cfg(8'h80, "R7 busy");
    write_cfg(8'h04, "R4 small clock rate side B");
    write_cfg(8'hFF, "R2 all ones");

    // R8: head load gated to the selected drive only.
    write_cfg(8'h09, "R8 setup");
    @(negedge clk);
    head_load_in = 1'b1;
    @(negedge clk);
    check("R8 big head drive1", 32'({big_head, small_head}), 32'h20);
    write_cfg(8'h02, "R8 move to small drive2");
    check("R8 small head drive2", 32'({big_head, small_head}), 32'h04);
    @(negedge clk);
    head_load_in = 1'b0;
    @(negedge clk);
    check("R8 heads drop", 32'({big_head, small_head}), 32'h00);

    // R9: settle delay, exact edge count.
    @(negedge clk);
    head_load_in = 1'b1;
    for (int k = 0; k <= SETTLE; k++) begin
      @(negedge clk);
      check("R9 still settling", 32'(head_settled), 32'd0);
    end
    @(negedge clk);
    check("R9 settled", 32'(head_settled), 32'd1);
    head_load_in = 1'b0;
    @(negedge clk);
    check("R9 falls with head load", 32'(head_settled), 32'd0);

    // R9: restart after a short drop partway through.
    head_load_in = 1'b1;
    repeat (3) @(negedge clk);
    head_load_in = 1'b0;
    @(negedge clk);
    head_load_in = 1'b1;
    for (int k = 0; k <= SETTLE; k++) begin
      @(negedge clk);
      check("R9 restarted delay", 32'(head_settled), 32'd0);
    end
    @(negedge clk);
    check("R9 settled after restart", 32'(head_settled), 32'd1);
    head_load_in = 1'b0;

    // R6: interrupt gate.
    write_cfg(8'h00, "R6 disable");
    intrq_in = 1'b1;
    @(negedge clk);
    check("R6 masked interrupt ignored", 32'(nmi_out), 32'd0);
    intrq_in = 1'b0;
    write_cfg(8'h20, "R6 enable");
    intrq_in = 1'b1;
    @(negedge clk);
    check("R6 enabled interrupt", 32'(nmi_out), 32'd1);
    intrq_in = 1'b0;
    @(negedge clk);
    check("R6 interrupt released", 32'(nmi_out), 32'd0);

    // R1: reset clears the stored byte.
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 cleared by reset", 32'(rd_data), 32'h0);

    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule